// File: doc/BRIEF.md
# Chip Erase Retry Sequencer

This block is the controller that sits next to an electrically erasable, byte-wide memory device and wipes it completely. A single `start` request makes it raise the erase-level programming supply and the high-voltage select on the dedicated address line. It then holds the address bus at zero and lowers the strobe for one long whole-chip erase pulse. After that it walks every address in erase-verify mode, and each byte there must read all ones (8'hFF). If any byte reads anything else, the block applies another whole-chip pulse and restarts the verify walk from address zero. This repeats until the pulse budget is spent.

When a verify walk completes cleanly, the supply select drops back to the normal level and every byte is read once more and compared with 8'hFF. That final walk decides the result. The block reports it with a one-cycle `done`, a `pass` bit, the number of pulses applied and the address that ended a failing run. All durations are parameter counts of clock cycles: setup, pulse width, hold and read access. The data bus is only sampled, on the last access cycle of each address, so it has no handshake. All control and status pins are plain levels or single-cycle pulses.

Top module: `chip_erase_seq`

## Requirements
- R1: After reset the block is idle: `dev_ce_n`, `dev_oe_n` and `dev_strb_n` are 1, `vpp_erase_sel`, `a9_hv_sel`, `busy`, `done` and `pass` are 0, and `dev_addr`, `pulse_count` and `fail_addr` are 0.
- R2: A `start` seen while idle begins a setup phase of SETUP_CYC cycles. In this phase `dev_ce_n`=0, `dev_oe_n`=1, `dev_strb_n`=1, `vpp_erase_sel`=1, `a9_hv_sel`=1 and `dev_addr`=0. A `start` seen while `busy` is 1 has no effect.
- R3: Each erase pulse holds `dev_strb_n` low for exactly PULSE_CYC consecutive cycles. Throughout the pulse `a9_hv_sel`=1, `vpp_erase_sel`=1, `dev_ce_n`=0, `dev_oe_n`=1 and `dev_addr`=0.
- R4: After each pulse come HOLD_CYC cycles with `dev_strb_n`=1, `dev_addr`=0 and both high-voltage selects still at 1.
- R5: A verify walk has `a9_hv_sel`=0, `vpp_erase_sel`=1, `dev_ce_n`=0, `dev_oe_n`=0 and `dev_strb_n`=1. It presents addresses 0 up to 2^ADDR_W-1 in ascending order, holds each for READ_CYC cycles, and samples `dev_data` in the last of those cycles.
- R6: If a verify sample is not 8'hFF and fewer than MAX_PULSES pulses have been applied, a new setup phase starts and is followed by a pulse and a verify walk from address 0.
- R7: `pulse_count` is cleared by an accepted `start` and increments by one on the cycle each pulse begins.
- R8: If a verify sample is not 8'hFF after MAX_PULSES pulses, the run ends with `pass`=0 and `fail_addr` equal to that address.
- R9: After a clean verify walk, a compare walk runs with the same timing and address order, but with `vpp_erase_sel`=0 and `a9_hv_sel`=0. A compare sample other than 8'hFF ends the run with `pass`=0 and `fail_addr` at that address. A clean compare walk ends it with `pass`=1.
- R10: `done` is 1 for exactly one cycle, the first idle cycle after a run, and `busy` is 0 in that cycle. `pass`, `pulse_count` and `fail_addr` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a chip erase (taken only while idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |
| pulse_count | output | $clog2(MAX_PULSES+1) | Erase pulses applied in the current or last run |
| fail_addr | output | ADDR_W | Address whose mismatch ended a failing run |
| dev_ce_n | output | 1 | Device chip enable, active low |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_strb_n | output | 1 | Device erase strobe, active low |
| dev_addr | output | ADDR_W | Device address bus |
| dev_data | input | 8 | Device data bus (read only) |
| vpp_erase_sel | output | 1 | Select erase-level programming supply |
| a9_hv_sel | output | 1 | Select high voltage on the dedicated address line |

## Verification
The bench uses a device model in which each byte needs its own number of pulses before it reads 8'hFF. A byte that needs three pulses tests whether a design restarts the walk from zero and keeps counting pulses. A design that only re-read the failing address, or that reset the count on a retry, would show the wrong address sequence or the wrong count. A byte that never clears tests the budget limit: an off-by-one design would apply one pulse too many or too few and report the wrong count or address. A byte that reads correctly only at erase-level supply tests the final compare, which a design that skipped it, or ran it with the erase supply still selected, would wrongly pass. A `start` issued mid-run checks that a busy design does not restart.

// File: rtl/cer_pkg.sv
package cer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_VERIFY,
    ST_COMPARE
  } cer_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/cer_timer.sv
module cer_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cer_scan.sv
module cer_scan #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (adv)  addr <= addr + 1'b1;
  end

  assign last = &addr;
endmodule

// File: rtl/chip_erase_seq.sv
module chip_erase_seq #(
  parameter int ADDR_W     = 18,
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 100000,
  parameter int HOLD_CYC   = 2,
  parameter int READ_CYC   = 1,
  parameter int MAX_PULSES = 20,
  localparam int CW = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CW-1:0]     pulse_count,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              dev_ce_n,
  output logic              dev_oe_n,
  output logic              dev_strb_n,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic [7:0]        dev_data,
  output logic              vpp_erase_sel,
  output logic              a9_hv_sel
);
  import cer_pkg::*;

  localparam int M1   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2   = (M1 > READ_CYC) ? M1 : READ_CYC;
  localparam int MAXC = (M2 > PULSE_CYC) ? M2 : PULSE_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  localparam logic [TW-1:0] LD_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] LD_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] LD_READ  = TW'(READ_CYC - 1);
  localparam logic [CW-1:0] BUDGET   = CW'(MAX_PULSES);

  cer_state_e st, st_n;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          s_clr, s_adv, s_last;
  logic [ADDR_W-1:0] s_addr;
  logic          fin, fin_ok, bump, accept;
  logic          byte_bad, scanning;

  cer_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  cer_scan #(.AW(ADDR_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .adv(s_adv), .addr(s_addr), .last(s_last)
  );

  assign byte_bad = (dev_data != ERASED_BYTE);
  assign scanning = (st == ST_VERIFY) || (st == ST_COMPARE);

  always_comb begin
    st_n   = st;
    t_load = 1'b0;
    t_val  = '0;
    s_clr  = 1'b0;
    s_adv  = 1'b0;
    fin    = 1'b0;
    fin_ok = 1'b0;
    bump   = 1'b0;
    accept = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        accept = 1'b1;
        st_n   = ST_SETUP;
        t_load = 1'b1;
        t_val  = LD_SETUP;
      end
      ST_SETUP: if (t_exp) begin
        st_n   = ST_PULSE;
        t_load = 1'b1;
        t_val  = LD_PULSE;
        bump   = 1'b1;
      end
      ST_PULSE: if (t_exp) begin
        st_n   = ST_HOLD;
        t_load = 1'b1;
        t_val  = LD_HOLD;
      end
      ST_HOLD: if (t_exp) begin
        st_n   = ST_VERIFY;
        t_load = 1'b1;
        t_val  = LD_READ;
        s_clr  = 1'b1;
      end
      ST_VERIFY, ST_COMPARE: if (t_exp) begin
        if (byte_bad) begin
          if ((st == ST_VERIFY) && (pulse_count < BUDGET)) begin
            st_n   = ST_SETUP;
            t_load = 1'b1;
            t_val  = LD_SETUP;
          end else begin
            st_n = ST_IDLE;
            fin  = 1'b1;
          end
        end else if (s_last) begin
          if (st == ST_VERIFY) begin
            st_n   = ST_COMPARE;
            t_load = 1'b1;
            t_val  = LD_READ;
            s_clr  = 1'b1;
          end else begin
            st_n   = ST_IDLE;
            fin    = 1'b1;
            fin_ok = 1'b1;
          end
        end else begin
          s_adv  = 1'b1;
          t_load = 1'b1;
          t_val  = LD_READ;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pulse_count <= '0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail_addr   <= '0;
    end else begin
      st   <= st_n;
      done <= fin;
      if (accept) begin
        pulse_count <= '0;
        pass        <= 1'b0;
        fail_addr   <= '0;
      end else begin
        if (bump) pulse_count <= pulse_count + 1'b1;
        if (fin) begin
          pass <= fin_ok;
          if (!fin_ok) fail_addr <= s_addr;
        end
      end
    end
  end

  assign busy          = (st != ST_IDLE);
  assign dev_ce_n      = (st == ST_IDLE);
  assign dev_oe_n      = !scanning;
  assign dev_strb_n    = (st != ST_PULSE);
  assign dev_addr      = scanning ? s_addr : '0;
  assign a9_hv_sel     = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_HOLD);
  assign vpp_erase_sel = busy && (st != ST_COMPARE);
endmodule

// File: rtl/cer_checker.sv
module cer_checker #(
  parameter int ADDR_W    = 18,
  parameter int PULSE_CYC = 100000,
  parameter int CW        = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [CW-1:0]     pulse_count,
  input logic              dev_ce_n,
  input logic              dev_oe_n,
  input logic              dev_strb_n,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              vpp_erase_sel,
  input logic              a9_hv_sel
);
  logic [31:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (dev_strb_n) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dev_ce_n && dev_oe_n && dev_strb_n && !vpp_erase_sel && !a9_hv_sel));

  a_r3_pulse_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_strb_n |-> (a9_hv_sel && vpp_erase_sel && !dev_ce_n && dev_oe_n && dev_addr == '0));

  a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_strb_n) |-> (low_run == 32'(PULSE_CYC)));

  a_r4_hold_hv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_strb_n) |-> (a9_hv_sel && vpp_erase_sel && dev_addr == '0));

  a_r5_read_no_hv: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe_n |-> (!a9_hv_sel && dev_strb_n && !dev_ce_n));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_strb_n) |-> (pulse_count == $past(pulse_count) + CW'(1)));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind chip_erase_seq cer_checker #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pulse_count(pulse_count),
  .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n), .dev_strb_n(dev_strb_n),
  .dev_addr(dev_addr), .vpp_erase_sel(vpp_erase_sel), .a9_hv_sel(a9_hv_sel)
);

// File: tb/chip_erase_seq_test.sv
module chip_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 3;
  localparam int NB    = 1 << AW;
  localparam int SET_C = 3;
  localparam int PUL_C = 5;
  localparam int HLD_C = 2;
  localparam int RD_C  = 2;
  localparam int MAXP  = 4;
  localparam int CW    = $clog2(MAXP + 1);

  localparam int P_IDLE = 0, P_SET = 1, P_PUL = 2, P_HLD = 3, P_VER = 4, P_CMP = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, done, pass;
  logic [CW-1:0] pulse_count;
  logic [AW-1:0] fail_addr, dev_addr;
  logic dev_ce_n, dev_oe_n, dev_strb_n, vpp_erase_sel, a9_hv_sel;
  logic [7:0] dev_data;

  logic [7:0] mem [NB];
  int need [NB];
  logic weak_en = 0;
  logic [AW-1:0] weak_addr = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  int m_ph, m_cnt, m_addr, m_pulses, m_fail;
  bit m_done, m_pass;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chip_erase_seq #(
    .ADDR_W(AW), .SETUP_CYC(SET_C), .PULSE_CYC(PUL_C), .HOLD_CYC(HLD_C),
    .READ_CYC(RD_C), .MAX_PULSES(MAXP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
    .pulse_count(pulse_count), .fail_addr(fail_addr), .dev_ce_n(dev_ce_n),
    .dev_oe_n(dev_oe_n), .dev_strb_n(dev_strb_n), .dev_addr(dev_addr),
    .dev_data(dev_data), .vpp_erase_sel(vpp_erase_sel), .a9_hv_sel(a9_hv_sel)
  );

  // Device model: a byte reads FF once it has seen its needed pulses;
  // the weak byte reads wrong only with the normal supply selected.
  assign dev_data = (!dev_ce_n && !dev_oe_n)
                  ? ((weak_en && !vpp_erase_sel && dev_addr == weak_addr) ? 8'hF7 : mem[dev_addr])
                  : 8'h00;

  always @(posedge dev_strb_n) begin
    if (rst_n && a9_hv_sel && vpp_erase_sel) begin
      for (int i = 0; i < NB; i++) begin
        if (need[i] > 0) need[i]--;
        if (need[i] == 0) mem[i] = 8'hFF;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_read(input int a, input bit normal);
    if (weak_en && normal && a == int'(weak_addr)) return 8'hF7;
    return mem[a];
  endfunction

  // Reference model: compared, then stepped, on every falling edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_cnt = 0; m_addr = 0; m_pulses = 0; m_fail = 0;
      m_done = 0; m_pass = 0;
    end else begin
      bit scan;
      scan = (m_ph == P_VER) || (m_ph == P_CMP);
      chk(dev_ce_n == (m_ph == P_IDLE), "R2", "dev_ce_n", dev_ce_n, m_ph == P_IDLE);
      chk(dev_strb_n == (m_ph != P_PUL), "R3", "dev_strb_n", dev_strb_n, m_ph != P_PUL);
      chk(a9_hv_sel == (m_ph == P_SET || m_ph == P_PUL || m_ph == P_HLD), "R4", "a9_hv_sel",
          a9_hv_sel, m_ph == P_SET || m_ph == P_PUL || m_ph == P_HLD);
      chk(dev_oe_n == !scan, "R5", "dev_oe_n", dev_oe_n, !scan);
      chk(int'(dev_addr) == (scan ? m_addr : 0), "R5", "dev_addr", dev_addr, scan ? m_addr : 0);
      chk(vpp_erase_sel == (m_ph != P_IDLE && m_ph != P_CMP), "R9", "vpp_erase_sel",
          vpp_erase_sel, m_ph != P_IDLE && m_ph != P_CMP);
      chk(int'(pulse_count) == m_pulses, "R7", "pulse_count", pulse_count, m_pulses);
      chk(busy == (m_ph != P_IDLE), "R10", "busy", busy, m_ph != P_IDLE);
      chk(done == m_done, "R10", "done", done, m_done);
      chk(pass == m_pass, "R9", "pass", pass, m_pass);
      chk(int'(fail_addr) == m_fail, "R8", "fail_addr", fail_addr, m_fail);

      m_done = 0;
      case (m_ph)
        P_IDLE: if (start) begin
          m_ph = P_SET; m_cnt = 0; m_pulses = 0; m_pass = 0; m_fail = 0;
        end
        P_SET: begin
          m_cnt++;
          if (m_cnt == SET_C) begin m_ph = P_PUL; m_cnt = 0; m_pulses++; end
        end
        P_PUL: begin
          m_cnt++;
          if (m_cnt == PUL_C) begin m_ph = P_HLD; m_cnt = 0; end
        end
        P_HLD: begin
          m_cnt++;
          if (m_cnt == HLD_C) begin m_ph = P_VER; m_cnt = 0; m_addr = 0; end
        end
        default: begin
          m_cnt++;
          if (m_cnt == RD_C) begin
            m_cnt = 0;
            if (model_read(m_addr, m_ph == P_CMP) != 8'hFF) begin
              if (m_ph == P_VER && m_pulses < MAXP) m_ph = P_SET;
              else begin
                m_ph = P_IDLE; m_done = 1; m_pass = 0; m_fail = m_addr;
              end
            end else if (m_addr == NB - 1) begin
              if (m_ph == P_VER) begin m_ph = P_CMP; m_addr = 0; end
              else begin m_ph = P_IDLE; m_done = 1; m_pass = 1; end
            end else m_addr++;
          end
        end
      endcase
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic fill(input int base_need);
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'h5A;
      need[i] = base_need;
    end
    weak_en = 0;
  endtask

  task automatic kick();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  initial begin
    fill(1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(dev_ce_n && dev_oe_n && dev_strb_n && !vpp_erase_sel && !a9_hv_sel && !busy
        && !done && !pass && pulse_count == 0 && dev_addr == 0 && fail_addr == 0,
        "R1", "idle outputs", {dev_ce_n, dev_oe_n, dev_strb_n, vpp_erase_sel, a9_hv_sel, busy}, 6'b111000);

    // One pulse clears all; a second start mid-run is ignored (R2).
    kick();
    repeat (6) @(posedge clk);
    #1 start = 1;
    @(posedge clk); #1 start = 0;
    wait_done();
    chk(pass == 1, "R9", "clean run pass", pass, 1);
    chk(pulse_count == 1, "R2", "count after mid-run start", pulse_count, 1);
    @(negedge clk);
    chk(done == 0, "R10", "done width", done, 0);
    repeat (4) @(negedge clk);
    chk(pass == 1 && pulse_count == 1, "R10", "status held", {pass, pulse_count}, {1'b1, CW'(1)});

    // Byte 5 needs three pulses: two retries with walk restarts.
    fill(1);
    need[5] = 3;
    kick();
    wait_done();
    chk(pass == 1, "R6", "retry run pass", pass, 1);
    chk(pulse_count == 3, "R6", "retry pulse count", pulse_count, 3);

    // Byte 2 never clears within the budget.
    fill(1);
    need[2] = 10;
    kick();
    wait_done();
    chk(pass == 0, "R8", "budget exhausted pass", pass, 0);
    chk(pulse_count == MAXP, "R8", "budget pulse count", pulse_count, MAXP);
    chk(fail_addr == 2, "R8", "budget fail address", fail_addr, 2);

    // Byte 6 reads FF only with the erase supply: the final compare catches it.
    fill(1);
    weak_en = 1;
    weak_addr = 3'd6;
    kick();
    wait_done();
    chk(pass == 0, "R9", "compare mismatch pass", pass, 0);
    chk(fail_addr == 6, "R9", "compare fail address", fail_addr, 6);
    chk(pulse_count == 1, "R7", "compare run count", pulse_count, 1);

    // Byte 7 (last address) needs two pulses.
    fill(1);
    need[7] = 2;
    kick();
    wait_done();
    chk(pass == 1 && pulse_count == 2, "R5", "last address retry", {pass, pulse_count}, {1'b1, CW'(2)});

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule